// File: doc/BRIEF.md
# Two-Sensor Axle Passage Tracker

This block follows one axle as it crosses a wheel detector built from two sensors mounted a short distance apart along the rail. Each clock cycle it samples the two sensor levels and moves a four-state machine to the state those levels describe. A one-bit substate records whether a single-sensor state was reached from the both-sensors state or from the idle state. Each state change bumps a set of per-axle counters. Two counters record direction steps around the sensor cycle, one records jumps between idle and both-affected, one records jumps between the two single-sensor states, and one records completed axles.

When the machine returns to idle, the per-axle counters, including that final step's increments, are added into a group accumulator and then cleared. A timeout-request pulse follows every state change, so an external timer can restart its interval. Evaluation of the group totals is left to the surrounding logic. All counters saturate instead of wrapping. The group width must be at least the per-axle width.

Top module: `axle_track_fsm`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows state 0, substate 0, timeout request 0, and every per-axle and group counter at 0.
- R2: With `rst` low, the state after a clock edge equals {sens2_i, sens1_i} sampled at that edge: 0 idle, 1 only sensor 1, 2 only sensor 2, 3 both.
- R3: On entering state 1 or 2, the substate becomes 1 if the previous state was 3 and 0 otherwise. In every other cycle it holds its value.
- R4: A single step along the ring 0→1→3→2→0 increments the R counter (field 1). A single step along 0→2→3→1→0 increments the L counter (field 0). No other counter changes on such a step, except as R7 adds.
- R5: A move between states 0 and 3, in either direction, increments only the G counter (field 2).
- R6: A move between states 1 and 2, in either direction, increments only the X counter (field 3).
- R7: A move from state 1 or 2 into state 0 also increments the A counter (field 4) when the substate is 1. When the substate is 0, A is unchanged.
- R8: On entering state 0, each group field becomes its old value plus the per-axle field including this step's increment, and all per-axle fields become 0. Per-axle fields are 0 whenever the state is 0.
- R9: When the sensor pair equals the current state, the state, the substate and all counters keep their values.
- R10: A per-axle field stops at 2^CW-1 and a group field stops at 2^GW-1. Neither wraps.
- R11: `tmo_req_o` is high in exactly the cycles that directly follow an edge where the state changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sens1_i | input | 1 | Sensor 1 affected level |
| sens2_i | input | 1 | Sensor 2 affected level |
| state_o | output | 2 | Current state code |
| from_both_o | output | 1 | Substate: single-sensor state entered from state 3 |
| tmo_req_o | output | 1 | One-cycle pulse after each state change |
| axle_cnt_o | output | 5*CW | Per-axle counters, field i at bits [i*CW +: CW], order L,R,G,X,A |
| group_cnt_o | output | 5*GW | Group counters, field i at bits [i*GW +: GW], same order |

## Verification
Regular passages in both directions separate the L and R counters and show A counting only when the axle went through state 3. Diagonal jumps 0↔3 and 1↔2 are checked to land only in G or X. Aborted passages, where the wheel backs out of a single-sensor state, show that A stays put when the substate is 0. Long 1↔3 oscillations with narrow widths drive both counter sets into saturation. A long seeded random walk with occasional resets then compares every output each cycle against a ring-position model, which catches wrong direction choices and mistimed folds.

// File: rtl/axc_pkg.sv
package axc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_S1   = 2'd1,
    ST_S2   = 2'd2,
    ST_BOTH = 2'd3
  } axc_state_e;

  localparam int NCNT = 5;
  localparam int IX_L = 0;
  localparam int IX_R = 1;
  localparam int IX_G = 2;
  localparam int IX_X = 3;
  localparam int IX_A = 4;
endpackage

// File: rtl/axc_step_decode.sv
module axc_step_decode
  import axc_pkg::*;
(
  input  axc_state_e             cur_i,
  input  axc_state_e             nxt_i,
  input  logic                   from_both_i,
  output logic [NCNT-1:0]        inc_o
);
  always_comb begin
    inc_o = '0;
    unique case ({cur_i, nxt_i})
      {ST_IDLE, ST_S1}:   inc_o[IX_R] = 1'b1;
      {ST_IDLE, ST_S2}:   inc_o[IX_L] = 1'b1;
      {ST_IDLE, ST_BOTH}: inc_o[IX_G] = 1'b1;
      {ST_S1,   ST_IDLE}: begin
        inc_o[IX_L] = 1'b1;
        inc_o[IX_A] = from_both_i;
      end
      {ST_S1,   ST_S2}:   inc_o[IX_X] = 1'b1;
      {ST_S1,   ST_BOTH}: inc_o[IX_R] = 1'b1;
      {ST_S2,   ST_IDLE}: begin
        inc_o[IX_R] = 1'b1;
        inc_o[IX_A] = from_both_i;
      end
      {ST_S2,   ST_S1}:   inc_o[IX_X] = 1'b1;
      {ST_S2,   ST_BOTH}: inc_o[IX_L] = 1'b1;
      {ST_BOTH, ST_IDLE}: inc_o[IX_G] = 1'b1;
      {ST_BOTH, ST_S1}:   inc_o[IX_L] = 1'b1;
      {ST_BOTH, ST_S2}:   inc_o[IX_R] = 1'b1;
      default:            inc_o = '0;
    endcase
  end
endmodule

// File: rtl/axc_state_track.sv
module axc_state_track
  import axc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sens1_i,
  input  logic       sens2_i,
  output axc_state_e state_o,
  output axc_state_e nxt_o,
  output logic       from_both_o,
  output logic       tmo_o
);
  axc_state_e state_q;
  logic       sub_q;
  logic       tmo_q;

  assign nxt_o = axc_state_e'({sens2_i, sens1_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sub_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= nxt_o;
      tmo_q   <= (nxt_o != state_q);
      if (nxt_o != state_q && (nxt_o == ST_S1 || nxt_o == ST_S2))
        sub_q <= (state_q == ST_BOTH);
    end
  end

  assign state_o     = state_q;
  assign from_both_o = sub_q;
  assign tmo_o       = tmo_q;

  // R3: substate moves only when a single-sensor state is entered
  a_r3_sub_entry: assert property (@(posedge clk) disable iff (rst)
    (!rst && !(nxt_o != state_q && (nxt_o == ST_S1 || nxt_o == ST_S2)))
      |=> (sub_q == $past(sub_q)));
endmodule

// File: rtl/axc_counter_pair.sv
module axc_counter_pair #(
  parameter int CW = 16,
  parameter int GW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          fold_i,
  output logic [CW-1:0] axle_o,
  output logic [GW-1:0] grp_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};

  logic [CW-1:0] axle_q;
  logic [GW-1:0] grp_q;
  logic [CW-1:0] bumped;
  logic [GW:0]   sum;

  assign bumped = (axle_q == CMAX) ? axle_q : axle_q + CW'(inc_i);
  assign sum    = {1'b0, grp_q} + (GW+1)'(bumped);

  always_ff @(posedge clk) begin
    if (rst) begin
      axle_q <= '0;
      grp_q  <= '0;
    end else if (fold_i) begin
      axle_q <= '0;
      grp_q  <= sum[GW] ? GMAX : sum[GW-1:0];
    end else begin
      axle_q <= bumped;
    end
  end

  assign axle_o = axle_q;
  assign grp_o  = grp_q;

  // R10: saturated counters never wrap
  a_r10_axle_sat: assert property (@(posedge clk) disable iff (rst)
    (axle_q == CMAX && !fold_i) |=> (axle_q == CMAX));
  a_r10_grp_sat: assert property (@(posedge clk) disable iff (rst)
    (grp_q == GMAX) |=> (grp_q == GMAX));
endmodule

// File: rtl/axle_track_fsm.sv
module axle_track_fsm
  import axc_pkg::*;
#(
  parameter int CW = 16,
  parameter int GW = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sens1_i,
  input  logic               sens2_i,
  output logic [1:0]         state_o,
  output logic               from_both_o,
  output logic               tmo_req_o,
  output logic [NCNT*CW-1:0] axle_cnt_o,
  output logic [NCNT*GW-1:0] group_cnt_o
);
  axc_state_e      cur;
  axc_state_e      nxt;
  logic            sub;
  logic            fold;
  logic [NCNT-1:0] inc;

  axc_state_track u_track (
    .clk        (clk),
    .rst        (rst),
    .sens1_i    (sens1_i),
    .sens2_i    (sens2_i),
    .state_o    (cur),
    .nxt_o      (nxt),
    .from_both_o(sub),
    .tmo_o      (tmo_req_o)
  );

  axc_step_decode u_dec (
    .cur_i      (cur),
    .nxt_i      (nxt),
    .from_both_i(sub),
    .inc_o      (inc)
  );

  assign fold = (cur != ST_IDLE) && (nxt == ST_IDLE);

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    axc_counter_pair #(.CW(CW), .GW(GW)) u_pair (
      .clk   (clk),
      .rst   (rst),
      .inc_i (inc[i]),
      .fold_i(fold),
      .axle_o(axle_cnt_o[i*CW +: CW]),
      .grp_o (group_cnt_o[i*GW +: GW])
    );
  end

  assign state_o     = cur;
  assign from_both_o = sub;

  // R2: state follows the sampled sensor pair
  a_r2_state_follows: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (state_o == $past({sens2_i, sens1_i})));
  // R11: request pulse exactly after a state change
  a_r11_tmo_pulse: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (tmo_req_o == (state_o != $past(state_o))));
  // R9: no movement, nothing changes
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && nxt == cur) |=> ($stable(from_both_o) && $stable(axle_cnt_o) && $stable(group_cnt_o)));
  // R8: idle means per-axle counters are empty
  a_r8_idle_empty: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0) |-> (axle_cnt_o == '0));
  // R4, R5, R6: direction, idle/both jump and side jump are exclusive
  a_r4_step_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inc[IX_L], inc[IX_R], inc[IX_G], inc[IX_X]}));
  // R7: axle count only on entry to idle
  a_r7_axle_on_idle: assert property (@(posedge clk) disable iff (rst)
    inc[IX_A] |-> (fold && sub));
endmodule

// File: tb/axle_track_fsm_tb.sv
module axle_track_fsm_tb;
  localparam int CW = 6;
  localparam int GW = 8;
  localparam int N  = 5;
  localparam int CMAX = (1 << CW) - 1;
  localparam int GMAX = (1 << GW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s1 = 1'b0;
  logic s2 = 1'b0;
  logic [1:0]      st;
  logic            fb;
  logic            tmo;
  logic [N*CW-1:0] ax;
  logic [N*GW-1:0] gp;

  int checks = 0;
  int fails  = 0;
  int e_st = 0, e_fb = 0, e_tmo = 0;
  int e_ax [N];
  int e_gp [N];

  always #10 clk = ~clk;

  axle_track_fsm #(.CW(CW), .GW(GW)) u_dut (
    .clk(clk), .rst(rst), .sens1_i(s1), .sens2_i(s2),
    .state_o(st), .from_both_o(fb), .tmo_req_o(tmo),
    .axle_cnt_o(ax), .group_cnt_o(gp)
  );

  function automatic int ring(input int s);
    case (s)
      0: return 0;
      1: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic a, input logic b, input logic r);
    int n, d;
    int inc [N];
    for (int i = 0; i < N; i++) inc[i] = 0;
    if (r) begin
      e_st = 0; e_fb = 0; e_tmo = 0;
      for (int i = 0; i < N; i++) begin e_ax[i] = 0; e_gp[i] = 0; end
      return;
    end
    n = {b, a};
    e_tmo = (n != e_st);
    if (n != e_st) begin
      d = (ring(n) - ring(e_st)) & 3;
      if (d == 1) inc[1] = 1;
      else if (d == 3) inc[0] = 1;
      else if (e_st == 0 || e_st == 3) inc[2] = 1;
      else inc[3] = 1;
      if (n == 0 && (e_st == 1 || e_st == 2) && e_fb == 1) inc[4] = 1;
      for (int i = 0; i < N; i++) begin
        e_ax[i] = e_ax[i] + inc[i];
        if (e_ax[i] > CMAX) e_ax[i] = CMAX;
      end
      if (n == 0) begin
        for (int i = 0; i < N; i++) begin
          e_gp[i] = e_gp[i] + e_ax[i];
          if (e_gp[i] > GMAX) e_gp[i] = GMAX;
          e_ax[i] = 0;
        end
      end
      if (n == 1 || n == 2) e_fb = (e_st == 3);
      e_st = n;
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "R2 state", st, e_st);
    chk(tag, "R3 substate", fb, e_fb);
    chk(tag, "R11 tmo_req", tmo, e_tmo);
    for (int i = 0; i < N; i++) begin
      chk(tag, "axle field", ax[i*CW +: CW], e_ax[i]);
      chk(tag, "group field", gp[i*GW +: GW], e_gp[i]);
    end
  endtask

  task automatic cyc(input logic a, input logic b, input logic r, input string tag);
    s1 = a; s2 = b; rst = r;
    @(posedge clk);
    model(a, b, r);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    report();
  end

  initial begin
    int unsigned seed;
    seed = 32'd4711;
    void'($urandom(seed));
    @(negedge clk);
    // R1 reset
    repeat (3) cyc(1'b0, 1'b0, 1'b1, "R1");
    chk("R1", "state", st, 0);
    chk("R1", "axle", ax, 0);
    chk("R1", "group", gp, 0);
    // R4 regular passage along 0-1-3-2-0, R7 axle counted
    cyc(1'b1, 1'b0, 1'b0, "R4");
    chk("R11", "tmo after change", tmo, 1);
    cyc(1'b1, 1'b1, 1'b0, "R4");
    cyc(1'b0, 1'b1, 1'b0, "R4");
    chk("R3", "from both", fb, 1);
    chk("R4", "r count", ax[1*CW +: CW], 3);
    cyc(1'b0, 1'b0, 1'b0, "R7");
    chk("R8", "group r", gp[1*GW +: GW], 4);
    chk("R7", "group a", gp[4*GW +: GW], 1);
    chk("R8", "axle cleared", ax, 0);
    // R4 opposite direction 0-2-3-1-0
    cyc(1'b0, 1'b1, 1'b0, "R4");
    cyc(1'b1, 1'b1, 1'b0, "R4");
    cyc(1'b1, 1'b0, 1'b0, "R4");
    cyc(1'b0, 1'b0, 1'b0, "R7");
    chk("R4", "group l", gp[0*GW +: GW], 4);
    chk("R7", "group a", gp[4*GW +: GW], 2);
    // R5 idle/both jumps
    cyc(1'b1, 1'b1, 1'b0, "R5");
    chk("R5", "g count", ax[2*CW +: CW], 1);
    cyc(1'b0, 1'b0, 1'b0, "R5");
    chk("R5", "group g", gp[2*GW +: GW], 2);
    // R6 side jump, substate 0 so no axle count
    cyc(1'b1, 1'b0, 1'b0, "R6");
    cyc(1'b0, 1'b1, 1'b0, "R6");
    chk("R6", "x count", ax[3*CW +: CW], 1);
    chk("R3", "substate after side jump", fb, 0);
    cyc(1'b0, 1'b0, 1'b0, "R7");
    chk("R7", "group a unchanged", gp[4*GW +: GW], 2);
    // aborted entry: 0-1-0, l step without axle
    cyc(1'b1, 1'b0, 1'b0, "R7");
    cyc(1'b0, 1'b0, 1'b0, "R7");
    chk("R7", "group a still", gp[4*GW +: GW], 2);
    // R9 hold
    cyc(1'b1, 1'b1, 1'b0, "R9");
    repeat (4) cyc(1'b1, 1'b1, 1'b0, "R9");
    chk("R9", "g held", ax[2*CW +: CW], 1);
    chk("R11", "tmo low while holding", tmo, 0);
    cyc(1'b0, 1'b0, 1'b0, "R9");
    // R10 saturation
    for (int k = 0; k < 5; k++) begin
      cyc(1'b1, 1'b0, 1'b0, "R10");
      for (int j = 0; j < 70; j++) begin
        cyc(1'b1, 1'b1, 1'b0, "R10");
        cyc(1'b1, 1'b0, 1'b0, "R10");
      end
      chk("R10", "l saturated", ax[0*CW +: CW], CMAX);
      cyc(1'b0, 1'b0, 1'b0, "R10");
    end
    chk("R10", "group r saturated", gp[1*GW +: GW], GMAX);
    // random walk
    cyc(1'b0, 1'b0, 1'b1, "R1");
    for (int k = 0; k < 4000; k++) begin
      int unsigned r;
      logic a, b, rr;
      r = $urandom % 100;
      a = s1; b = s2; rr = 1'b0;
      if (r < 40) a = ~a;
      else if (r < 75) b = ~b;
      else if (r < 85) begin a = ~a; b = ~b; end
      else if (r == 99) rr = 1'b1;
      cyc(a, b, rr, "R2");
    end
    report();
  end
endmodule